// File: doc/BRIEF.md
# Overlay ROM/RAM Paging Controller

This controller sits on an 8-bit CPU bus with Z80-style strobes. It decides when an 8 KB add-on ROM and an 8 KB add-on RAM take the place of the lowest 16 KB of host memory. Two write-only I/O port addresses turn the overlay on and off. A front-panel freeze button raises a one-cycle NMI request. The same press pages the overlay in, so that the CPU takes its NMI vector from the add-on ROM. While the overlay is paged in, the controller disables the host's own memory in the lower 16 KB. CPU writes there reach the add-on RAM, or go nowhere, and never touch host RAM.

The controller also holds a one-way invisibility flag. After reset the overlay is visible and the two ports are obeyed. Once a freeze has been serviced, the handler returns to the interrupted program through a return instruction at 0064h/0065h. An opcode fetch from either of those two addresses pages the overlay out and hides it. From then on the ports and the freeze button are ignored until the next reset.

All chip selects and the host-memory disable are decoded combinationally from the current bus cycle. All state changes take effect on the rising clock edge at which the qualifying strobes are sampled.

Top module: `ovl_pager`

## Requirements
- R1: Synchronous reset, active high, leaves the overlay paged out, armed clear and visible. After reset `rom_cs_n` and `ram_cs_n` are 1 and `host_mem_dis` and `nmi_req` are 0.
- R2: An I/O write (IORQ and WR low, M1 high) sets the paging state on the next edge when the address satisfies (addr & FFFDh) == FEE8h. Address bit 1 = 0 pages the overlay in and bit 1 = 1 pages it out. Any other address, any I/O read and any interrupt-acknowledge cycle (M1 and IORQ low) leave the state unchanged.
- R3: While paged in, `rom_cs_n` is 0 exactly for memory reads with address below 2000h. Memory writes never select the ROM.
- R4: While paged in, `ram_cs_n` is 0 for memory reads and memory writes with address in 2000h–3FFFh.
- R5: `host_mem_dis` is 1 exactly when the overlay is paged in, MREQ is low and the address is below 4000h.
- R6: While paged out, `rom_cs_n` and `ram_cs_n` stay 1 and `host_mem_dis` stays 0 for every bus cycle.
- R7: A rising edge on `freeze_btn` while visible raises `nmi_req` for exactly one cycle, starting at the next clock edge. The same edge pages the overlay in and arms the invisibility flag. Holding the button does not repeat the request.
- R8: Once armed, an opcode fetch (M1, MREQ and RD low) at 0064h or 0065h is still served from the add-on ROM. On the following edge the overlay is paged out and becomes invisible.
- R9: Before any freeze, opcode fetches at 0064h/0065h do not hide the overlay, and the ports keep working.
- R10: While invisible, port writes and freeze presses change nothing and no NMI is raised. A read of 0065h without M1 never hides the overlay.
- R11: A reset makes the overlay visible again, and the ports are obeyed once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU address bus |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| freeze_btn | input | 1 | Freeze push button, active high, synchronous to clk |
| rom_cs_n | output | 1 | Add-on ROM select, active low |
| ram_cs_n | output | 1 | Add-on RAM select, active low |
| host_mem_dis | output | 1 | Disables host ROM/RAM in 0000h–3FFFh |
| nmi_req | output | 1 | One-cycle NMI request to the CPU |

## Verification
A wrong paging bit shows at the ports as soon as the next memory cycle in the lower 16 KB. The bench probes it with a plain read at 0100h, one cycle after each stimulus. A wrong armed or invisible flag shows only later, at the ports: a hook fetch that fails to page the overlay out, a port write that should have been ignored, or an NMI pulse after the overlay has hidden. The bench therefore follows each freeze and hook sequence with port writes and a second press, each probed on the cycle after it.

// File: rtl/ovl_pager.sv
`timescale 1ns/1ps
module ovl_pager #(
  parameter logic [15:0] PORT_ADDR = 16'hFEE8,
  parameter logic [15:0] PORT_SEL  = 16'h0002,
  parameter logic [15:0] HOOK_ADDR = 16'h0064,
  parameter int          BANK_BITS = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        m1_n,
  input  logic        mreq_n,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        freeze_btn,
  output logic        rom_cs_n,
  output logic        ram_cs_n,
  output logic        host_mem_dis,
  output logic        nmi_req
);
  localparam int HI_W = 16 - BANK_BITS;
  localparam logic [15:0] PORT_CARE = ~PORT_SEL;

  logic en_q, armed_q, hidden_q, frz_q, nmi_q;

  wire mem_rd   = !mreq_n && !rd_n;
  wire mem_wr   = !mreq_n && !wr_n;
  wire io_wr    = !iorq_n && !wr_n && m1_n;
  wire port_hit = io_wr && ((addr & PORT_CARE) == (PORT_ADDR & PORT_CARE));
  wire port_off = |(addr & PORT_SEL);
  wire press    = freeze_btn && !frz_q && !hidden_q;
  wire fetch    = !m1_n && mem_rd;
  wire hook_hit = armed_q && fetch && (addr[15:1] == HOOK_ADDR[15:1]);

  wire [HI_W-1:0] bank = addr[15:BANK_BITS];
  wire in_rom  = (bank == HI_W'(0));
  wire in_ram  = (bank == HI_W'(1));
  wire in_low  = in_rom || in_ram;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      armed_q  <= 1'b0;
      hidden_q <= 1'b0;
      frz_q    <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      frz_q <= freeze_btn;
      nmi_q <= press;
      if (press) begin
        en_q    <= 1'b1;
        armed_q <= 1'b1;
      end else if (hook_hit) begin
        en_q     <= 1'b0;
        armed_q  <= 1'b0;
        hidden_q <= 1'b1;
      end else if (port_hit && !hidden_q) begin
        en_q <= !port_off;
      end
    end
  end

  assign rom_cs_n     = !(en_q && mem_rd && in_rom);
  assign ram_cs_n     = !(en_q && (mem_rd || mem_wr) && in_ram);
  assign host_mem_dis = en_q && !mreq_n && in_low;
  assign nmi_req      = nmi_q;

  AST_PORT_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (port_hit && !hidden_q && !press && !hook_hit && !port_off) |=> en_q); // R2
  AST_PORT_DISABLE: assert property (@(posedge clk) disable iff (rst)
    (port_hit && !hidden_q && !press && !hook_hit && port_off) |=> !en_q); // R2
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!rom_cs_n && !ram_cs_n)); // R3
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_n && !rom_cs_n) |-> 1'b0); // R3
  AST_HOST_OFF_ROM: assert property (@(posedge clk) disable iff (rst)
    (!rom_cs_n || !ram_cs_n) |-> host_mem_dis); // R5
  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> !nmi_req); // R7
  AST_NMI_PAGES_IN: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> (en_q && armed_q)); // R7
  AST_HOOK_HIDES: assert property (@(posedge clk) disable iff (rst)
    (hook_hit && !press) |=> (hidden_q && !en_q)); // R8
  AST_HIDDEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    hidden_q |=> hidden_q); // R10
  AST_HIDDEN_OFF: assert property (@(posedge clk) disable iff (rst)
    hidden_q |-> (rom_cs_n && ram_cs_n && !host_mem_dis)); // R10
  AST_HIDDEN_NO_NMI: assert property (@(posedge clk) disable iff (rst)
    hidden_q |=> !nmi_req); // R10
endmodule

// File: tb/ovl_pager_tb.sv
`timescale 1ns/1ps
module ovl_pager_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, m1_n, mreq_n, iorq_n, rd_n, wr_n, freeze_btn;
  logic [15:0] addr;
  logic rom_cs_n, ram_cs_n, host_mem_dis, nmi_req;
  int n_cmp = 0, n_bad = 0;

  ovl_pager u_dut (
    .clk(clk), .rst(rst), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .freeze_btn(freeze_btn),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .host_mem_dis(host_mem_dis),
    .nmi_req(nmi_req));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr = 16'h0000; m1_n = 1'b1; mreq_n = 1'b1; iorq_n = 1'b1;
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); freeze_btn = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic io_cycle(input logic [15:0] a, input logic is_wr, input logic m1);
    @(negedge clk); idle(); addr = a; iorq_n = 1'b0; m1_n = ~m1;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk); idle();
  endtask

  task automatic probe(input string tag, input logic exp);
    @(negedge clk); idle(); addr = 16'h0100; mreq_n = 1'b0; rd_n = 1'b0;
    #1 chk(tag, 16'(!rom_cs_n), 16'(exp));
  endtask

  task automatic fetch(input logic [15:0] a, input logic m1, input string tag);
    @(negedge clk); idle(); addr = a; mreq_n = 1'b0; rd_n = 1'b0; m1_n = ~m1;
    #1 chk(tag, 16'(!rom_cs_n), 16'(a < 16'h2000));
  endtask

  task automatic press_freeze(input logic exp_nmi, input string tag);
    @(negedge clk); idle(); freeze_btn = 1'b1;
    @(negedge clk); #1 chk(tag, 16'(nmi_req), 16'(exp_nmi));
    @(negedge clk); #1 chk({tag, " held"}, 16'(nmi_req), 16'h0);
    freeze_btn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(); freeze_btn = 1'b0; rst = 1'b1;
    do_reset();
    @(negedge clk); #1;
    chk("R1 nmi", 16'(nmi_req), 16'h0);
    probe("R1 paged out", 1'b0);
    #1 chk("R1 host dis", 16'(host_mem_dis), 16'h0);
    chk("R1 ram cs", 16'(ram_cs_n), 16'h1);

    // R2 port decode sweep
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 24; v++) begin
        logic [15:0] a;
        logic exp;
        if (v < 16) a = 16'hFEE0 | 16'(v);
        else case (v)
          16: a = 16'h7EE8; 17: a = 16'hFFE8; 18: a = 16'hFEF8; 19: a = 16'hFEC8;
          20: a = 16'hBEEA; 21: a = 16'hFAE8; 22: a = 16'h7F89; default: a = 16'hFEE9;
        endcase
        io_cycle(s ? 16'hFEE8 : 16'hFEEA, 1'b1, 1'b0);
        io_cycle(a, 1'b1, 1'b0);
        exp = ((a & 16'hFFFD) == 16'hFEE8) ? ~a[1] : s[0];
        probe($sformatf("R2 port %h from %0d", a, s), exp);
      end
      io_cycle(s ? 16'hFEE8 : 16'hFEEA, 1'b1, 1'b0);
      io_cycle(s ? 16'hFEEA : 16'hFEE8, 1'b0, 1'b0);
      probe("R2 io read ignored", s[0]);
      io_cycle(s ? 16'hFEEA : 16'hFEE8, 1'b1, 1'b1);
      probe("R2 int ack ignored", s[0]);
    end

    // R3 R4 R5 R6 decode sweep
    for (int e = 0; e < 2; e++) begin
      io_cycle(e ? 16'hFEE8 : 16'hFEEA, 1'b1, 1'b0);
      for (int h = 0; h < 256; h++) begin
        for (int op = 0; op < 3; op++) begin
          logic [15:0] a;
          logic er, ew, ec, xr, xw, xh;
          a = {8'(h), (h % 2 == 1) ? 8'hFF : 8'h00};
          @(negedge clk); idle(); addr = a;
          er = (op == 0); ew = (op == 1);
          if (op != 2) mreq_n = 1'b0;
          if (op == 0 || op == 2) rd_n = 1'b0;
          if (op == 1) wr_n = 1'b0;
          ec = e[0];
          xr = ec && er && (a < 16'h2000);
          xw = ec && (er || ew) && (a >= 16'h2000) && (a < 16'h4000);
          xh = ec && (op != 2) && (a < 16'h4000);
          #1 chk($sformatf("R3 R4 R5 R6 en=%0d op=%0d a=%h", e, op, a),
                 16'({!rom_cs_n, !ram_cs_n, host_mem_dis}), 16'({xr, xw, xh}));
        end
      end
    end

    // R9: hook fetches before any freeze do nothing
    do_reset();
    io_cycle(16'hFEE8, 1'b1, 1'b0);
    fetch(16'h0065, 1'b1, "R9 fetch 0065 served");
    fetch(16'h0064, 1'b1, "R9 fetch 0064 served");
    probe("R9 still paged in", 1'b1);
    io_cycle(16'hFEEA, 1'b1, 1'b0);
    probe("R9 port still works", 1'b0);

    // R7 R8 run A via 0065
    press_freeze(1'b1, "R7 nmi pulse");
    probe("R7 paged in by freeze", 1'b1);
    fetch(16'h0066, 1'b1, "R8 nmi vector from rom");
    fetch(16'h0065, 1'b0, "R10 plain read 0065");
    probe("R10 plain read no hide", 1'b1);
    fetch(16'h0065, 1'b1, "R8 hook fetch served");
    probe("R8 paged out after hook", 1'b0);
    #1 chk("R8 host dis off", 16'(host_mem_dis), 16'h0);

    // R10 hidden
    io_cycle(16'hFEE8, 1'b1, 1'b0);
    probe("R10 port ignored", 1'b0);
    press_freeze(1'b0, "R10 freeze ignored");
    probe("R10 stays out", 1'b0);

    // R11 reset restores; run B via 0064
    do_reset();
    io_cycle(16'hFEE8, 1'b1, 1'b0);
    probe("R11 visible again", 1'b1);
    io_cycle(16'hFEEA, 1'b1, 1'b0);
    press_freeze(1'b1, "R7 second run nmi");
    fetch(16'h0064, 1'b1, "R8 hook 0064 served");
    probe("R8 0064 hides", 1'b0);
    io_cycle(16'hFEE8, 1'b1, 1'b0);
    probe("R10 port ignored after 0064", 1'b0);

    @(negedge clk); idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule